// File: doc/BRIEF.md
# Two-Wire Bus Master Byte Engine

This block drives a two-wire serial bus (SCL and SDA, both open drain) as the only master on it. Software steers it one bus step at a time through an 8-bit control register and an 8-bit data register. Each step is one of these: a START condition, a repeated START, one byte written out, one byte read in, or a STOP. When a step finishes, the block sets a completion flag, raises `irq` and posts an 8-bit status code. The bus then waits with SCL held low until software writes the control register again.

Bus timing comes from the `tick` clock-enable input. Every bit takes four ticks: SCL low, SDA update, SCL released, SDA sampled. The first byte after a START is the address byte, which is the 7-bit target address shifted left by one with the direction bit in bit 0. Its direction bit decides whether the data bytes that follow are written or read. Received bytes are answered with ACK or NACK as the control register's acknowledge bit selects. If the block releases SDA to send a 1 but samples it low, it reports lost arbitration and lets go of the bus.

The controller has five states. IDLE means the bus is free. START_GEN runs a START or repeated START. HOLD means SCL is held low after a step and the engine waits for software. SHIFT moves nine bits, which are eight data bits and the acknowledge bit. STOP_GEN runs a STOP. The transitions are:
- IDLE→START_GEN on an accepted command with the start bit set.
- HOLD→START_GEN when the start bit is set.
- HOLD→STOP_GEN when the stop bit is set and the start bit is not.
- HOLD→SHIFT when neither is set.
- START_GEN→HOLD and SHIFT→HOLD when the step completes.
- SHIFT→IDLE on arbitration loss.
- STOP_GEN→IDLE when the STOP is done.

Top module: `i2c_byte_engine`

## Requirements
- R1: After reset the status reads 0xF8, the control and data registers read 0x00, `irq` is low and neither bus line is pulled low. Whenever the engine is in IDLE, both lines are released.
- R2: The control register layout is: bit 7 = clock-enable (CE), bit 6 = enable, bit 5 = start, bit 4 = stop, bit 3 = completion flag, bit 2 = acknowledge, bits 1:0 plain storage. A write can clear the completion flag but never set it. A write is a command only when it has enable = 1 and flag = 0.
- R3: A start command from IDLE produces a START condition, meaning SDA falls while SCL is high. The status becomes 0x08, the flag and `irq` are set, the start bit clears, and SCL stays low in HOLD.
- R4: The address byte goes out MSB first. The status is 0x18 or 0x20 for a write address (bit 0 = 0) with ACK or NACK received, and 0x40 or 0x48 for a read address (bit 0 = 1) with ACK or NACK received.
- R5: In write direction each data byte goes out MSB first. The status is 0x28 when it is ACKed and 0x30 when it is NACKed.
- R6: In read direction the byte is assembled MSB first into the data register. With acknowledge = 1 the engine drives ACK (SDA low) on the ninth bit and reports 0x50. With acknowledge = 0 it leaves SDA high (NACK) and reports 0x58.
- R7: A start command issued from HOLD produces a repeated START, reports 0x10, and makes the next byte an address byte.
- R8: A stop command (enable and stop set, start clear) from HOLD produces a STOP condition, meaning SDA rises while SCL is high. The engine then returns to IDLE with status 0xF8, the flag clear and the stop bit cleared.
- R9: If SDA is sampled low during a data bit in which the engine sends a 1, the engine reports 0x38, sets the flag and releases both lines.
- R10: A control write with enable = 0 starts nothing: no bus activity occurs and the status is unchanged.
- R11: While a step is in progress, the status reads 0xF8 and `irq` is low.
- R12: During a byte transfer SDA changes only while SCL is low, so no START or STOP appears on the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Bus timing enable; each bit takes four ticks |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 = control register, 1 = data register |
| reg_wdata | input | 8 | Write data |
| ctl_rd | output | 8 | Control register readback |
| data_rd | output | 8 | Data register readback |
| status_rd | output | 8 | Status code |
| irq | output | 1 | Completion flag |
| sda_in | input | 1 | Sampled SDA line level |
| scl_pull | output | 1 | 1 pulls SCL low |
| sda_pull | output | 1 | 1 pulls SDA low |

## Verification
A wrong state or phase shows up on the bus lines within one tick. Examples are a spurious START or STOP edge, or a bit that is sampled before SCL has risen. The same fault also shows up at the next completion as a wrong status code or a wrong captured byte. A wrong direction flag or address-phase flag only becomes visible one step later, when the status family (0x18, 0x28, 0x40 or 0x50) comes out wrong. For that reason every step's status is compared when it completes, and the start and stop edge counts are compared after each byte.

// File: rtl/i2c_eng_pkg.sv
package i2c_eng_pkg;
    localparam int ENG_BYTE_W = 8;
    localparam int ENG_PHASES = 4;

    localparam int CTL_AAK  = 2;
    localparam int CTL_FLAG = 3;
    localparam int CTL_STP  = 4;
    localparam int CTL_STA  = 5;
    localparam int CTL_ENAB = 6;

    localparam logic [7:0] SC_START    = 8'h08;
    localparam logic [7:0] SC_RSTART   = 8'h10;
    localparam logic [7:0] SC_AW_ACK   = 8'h18;
    localparam logic [7:0] SC_AW_NAK   = 8'h20;
    localparam logic [7:0] SC_DW_ACK   = 8'h28;
    localparam logic [7:0] SC_DW_NAK   = 8'h30;
    localparam logic [7:0] SC_ARB      = 8'h38;
    localparam logic [7:0] SC_AR_ACK   = 8'h40;
    localparam logic [7:0] SC_AR_NAK   = 8'h48;
    localparam logic [7:0] SC_DR_ACK   = 8'h50;
    localparam logic [7:0] SC_DR_NAK   = 8'h58;
    localparam logic [7:0] SC_NONE     = 8'hF8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START_GEN,
        ST_HOLD,
        ST_SHIFT,
        ST_STOP_GEN
    } eng_state_t;
endpackage

// File: rtl/i2c_eng_phase.sv
module i2c_eng_phase #(
    parameter int PHASES = 4,
    localparam int QW = $clog2(PHASES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          tick,
    output logic [QW-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (clr) begin
            q <= '0;
        end else if (tick) begin
            if (q == QW'(PHASES - 1)) q <= '0;
            else                      q <= q + 1'b1;
        end
    end
endmodule

// File: rtl/i2c_eng_shifter.sv
module i2c_eng_shifter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         shift,
    input  logic         in_bit,
    output logic [W-1:0] value
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     value <= '0;
        else if (load)  value <= load_val;
        else if (shift) value <= {value[W-2:0], in_bit};
    end
endmodule

// File: rtl/i2c_byte_engine.sv
module i2c_byte_engine
    import i2c_eng_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  tick,
    input  logic                  reg_we,
    input  logic                  reg_sel,
    input  logic [ENG_BYTE_W-1:0] reg_wdata,
    output logic [7:0]            ctl_rd,
    output logic [ENG_BYTE_W-1:0] data_rd,
    output logic [7:0]            status_rd,
    output logic                  irq,
    input  logic                  sda_in,
    output logic                  scl_pull,
    output logic                  sda_pull
);
    localparam int QW = $clog2(ENG_PHASES);
    localparam int CW = $clog2(ENG_BYTE_W + 1);
    localparam logic [CW-1:0] LAST_BIT = CW'(ENG_BYTE_W);

    eng_state_t state_q, state_d;

    logic [7:0]            ctl_q;
    logic [ENG_BYTE_W-1:0] data_q;
    logic [7:0]            status_q;
    logic [CW-1:0]         bitcnt_q;
    logic                  rd_mode_q, addr_phase_q, restart_q;
    logic                  scl_lo_q, sda_lo_q;
    logic [QW-1:0]         q;
    logic [ENG_BYTE_W-1:0] sh_val;

    logic cmd, ctl_wr, at_rest, step_end, data_bit, tx_dir, arb_lost, ack_seen;

    assign ctl_wr   = reg_we && !reg_sel && at_rest;
    assign cmd      = ctl_wr && reg_wdata[CTL_ENAB] && !reg_wdata[CTL_FLAG];
    assign at_rest  = (state_q == ST_IDLE) || (state_q == ST_HOLD);
    assign step_end = tick && (q == QW'(ENG_PHASES - 1));
    assign data_bit = bitcnt_q < LAST_BIT;
    assign tx_dir   = addr_phase_q || !rd_mode_q;
    assign arb_lost = (state_q == ST_SHIFT) && step_end && data_bit && tx_dir
                      && !sda_lo_q && !sda_in;
    assign ack_seen = !sda_in;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (cmd && reg_wdata[CTL_STA]) state_d = ST_START_GEN;
            ST_HOLD: begin
                if (cmd) begin
                    if (reg_wdata[CTL_STA])      state_d = ST_START_GEN;
                    else if (reg_wdata[CTL_STP]) state_d = ST_STOP_GEN;
                    else                         state_d = ST_SHIFT;
                end
            end
            ST_START_GEN: if (step_end) state_d = ST_HOLD;
            ST_SHIFT: begin
                if (arb_lost)                               state_d = ST_IDLE;
                else if (step_end && bitcnt_q == LAST_BIT) state_d = ST_HOLD;
            end
            ST_STOP_GEN:  if (step_end) state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    i2c_eng_phase #(.PHASES(ENG_PHASES)) u_phase (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (state_d != state_q),
        .tick  (tick),
        .q     (q)
    );

    i2c_eng_shifter #(.W(ENG_BYTE_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (state_q == ST_HOLD && state_d == ST_SHIFT),
        .load_val (data_q),
        .shift    (state_q == ST_SHIFT && step_end && data_bit && !arb_lost),
        .in_bit   (sda_in),
        .value    (sh_val)
    );

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q        <= '0;
            data_q       <= '0;
            status_q     <= SC_NONE;
            bitcnt_q     <= '0;
            rd_mode_q    <= 1'b0;
            addr_phase_q <= 1'b0;
            restart_q    <= 1'b0;
            scl_lo_q     <= 1'b0;
            sda_lo_q     <= 1'b0;
        end else begin
            if (reg_we && reg_sel && at_rest) data_q <= reg_wdata;
            if (ctl_wr) begin
                ctl_q <= reg_wdata[7:0];
                ctl_q[CTL_FLAG] <= reg_wdata[CTL_FLAG] & ctl_q[CTL_FLAG];
            end
            if (at_rest && state_d != state_q) begin
                status_q  <= SC_NONE;
                bitcnt_q  <= '0;
                restart_q <= (state_q == ST_HOLD);
            end
            if (tick) begin
                unique case (state_q)
                    ST_START_GEN: begin
                        unique case (q)
                            2'd0: sda_lo_q <= 1'b0;
                            2'd1: scl_lo_q <= 1'b0;
                            2'd2: sda_lo_q <= 1'b1;
                            default: begin
                                scl_lo_q       <= 1'b1;
                                status_q       <= restart_q ? SC_RSTART : SC_START;
                                ctl_q[CTL_FLAG] <= 1'b1;
                                ctl_q[CTL_STA] <= 1'b0;
                                addr_phase_q   <= 1'b1;
                            end
                        endcase
                    end
                    ST_SHIFT: begin
                        unique case (q)
                            2'd0: scl_lo_q <= 1'b1;
                            2'd1: begin
                                if (data_bit) sda_lo_q <= tx_dir ? ~sh_val[ENG_BYTE_W-1] : 1'b0;
                                else          sda_lo_q <= tx_dir ? 1'b0 : ctl_q[CTL_AAK];
                            end
                            2'd2: scl_lo_q <= 1'b0;
                            default: begin
                                if (arb_lost) begin
                                    scl_lo_q        <= 1'b0;
                                    sda_lo_q        <= 1'b0;
                                    status_q        <= SC_ARB;
                                    ctl_q[CTL_FLAG] <= 1'b1;
                                    addr_phase_q    <= 1'b0;
                                    rd_mode_q       <= 1'b0;
                                end else if (data_bit) begin
                                    bitcnt_q <= bitcnt_q + 1'b1;
                                end else begin
                                    scl_lo_q        <= 1'b1;
                                    ctl_q[CTL_FLAG] <= 1'b1;
                                    addr_phase_q    <= 1'b0;
                                    if (addr_phase_q) begin
                                        rd_mode_q <= sh_val[0];
                                        if (sh_val[0]) status_q <= ack_seen ? SC_AR_ACK : SC_AR_NAK;
                                        else           status_q <= ack_seen ? SC_AW_ACK : SC_AW_NAK;
                                    end else if (!rd_mode_q) begin
                                        status_q <= ack_seen ? SC_DW_ACK : SC_DW_NAK;
                                    end else begin
                                        data_q   <= sh_val;
                                        status_q <= ctl_q[CTL_AAK] ? SC_DR_ACK : SC_DR_NAK;
                                    end
                                end
                            end
                        endcase
                    end
                    ST_STOP_GEN: begin
                        unique case (q)
                            2'd0: scl_lo_q <= 1'b1;
                            2'd1: sda_lo_q <= 1'b1;
                            2'd2: scl_lo_q <= 1'b0;
                            default: begin
                                sda_lo_q       <= 1'b0;
                                status_q       <= SC_NONE;
                                ctl_q[CTL_STP] <= 1'b0;
                                addr_phase_q   <= 1'b0;
                                rd_mode_q      <= 1'b0;
                            end
                        endcase
                    end
                    default: ;
                endcase
            end
        end
    end

    assign ctl_rd    = ctl_q;
    assign data_rd   = data_q;
    assign status_rd = status_q;
    assign irq       = ctl_q[CTL_FLAG];
    assign scl_pull  = scl_lo_q;
    assign sda_pull  = sda_lo_q;
endmodule

// File: rtl/i2c_byte_engine_chk.sv
module i2c_byte_engine_chk
    import i2c_eng_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input eng_state_t state,
    input logic       scl_pull,
    input logic       sda_pull,
    input logic       irq,
    input logic [7:0] status
);
    p_busy_status_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_START_GEN || state == ST_SHIFT || state == ST_STOP_GEN)
        |-> (status == 8'hF8 && !irq));

    p_hold_scl_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD) |-> scl_pull);

    p_sda_stable_high_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SHIFT && !scl_pull && $past(!scl_pull)) |-> $stable(sda_pull));

    p_stop_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state == ST_STOP_GEN) && state == ST_IDLE)
        |-> (status == 8'hF8 && !scl_pull && !sda_pull));

    p_idle_released_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> (!scl_pull && !sda_pull));

    p_arb_released_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && status == 8'h38) |-> (!scl_pull && !sda_pull));
endmodule

bind i2c_byte_engine i2c_byte_engine_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .state    (state_q),
    .scl_pull (scl_pull),
    .sda_pull (sda_pull),
    .irq      (irq),
    .status   (status_rd)
);

// File: tb/i2c_byte_engine_tb.sv
`timescale 1ns/1ps
module i2c_byte_engine_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       reg_we = 1'b0;
    logic       reg_sel = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] ctl_rd, data_rd, status_rd;
    logic       irq, scl_pull, sda_pull;
    logic       slv_lo = 1'b0;
    logic       scl, sda;

    int errs = 0;
    int checks = 0;
    int start_cnt = 0;
    int stop_cnt = 0;
    bit done = 1'b0;

    assign scl = ~scl_pull;
    assign sda = ~(sda_pull | slv_lo);

    i2c_byte_engine u_dut (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .ctl_rd(ctl_rd), .data_rd(data_rd), .status_rd(status_rd), .irq(irq),
        .sda_in(sda), .scl_pull(scl_pull), .sda_pull(sda_pull)
    );

    always #2.5 clk = ~clk;
    always @(negedge clk) tick <= ~tick;

    always @(negedge sda) if (scl === 1'b1) start_cnt++;
    always @(posedge sda) if (scl === 1'b1) stop_cnt++;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input bit sel, input logic [7:0] v);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = sel; reg_wdata = v;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic wait_irq();
        while (irq !== 1'b1) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic start_step(input logic [7:0] exp, input string tag);
        int s0;
        s0 = start_cnt;
        wr(1'b0, 8'h60);
        wait_irq();
        chk(status_rd == exp, tag, status_rd, exp);
        chk(start_cnt == s0 + 1, {tag, " start edge"}, start_cnt, s0 + 1);
        chk(ctl_rd == 8'h48, {tag, " ctl"}, ctl_rd, 8'h48);
    endtask

    task automatic tx_byte(input logic [7:0] b, input bit ack, input logic [7:0] exp,
                           input string tag);
        logic [7:0] got;
        int s0, p0;
        s0 = start_cnt; p0 = stop_cnt; got = 8'h00;
        wr(1'b1, b);
        wr(1'b0, 8'h40);
        for (int i = 0; i < 8; i++) begin
            @(posedge scl);
            got = {got[6:0], sda};
            if (i == 0) chk(status_rd == 8'hF8 && !irq, "R11 busy status", status_rd, 8'hF8);
        end
        @(negedge scl); slv_lo = ack;
        @(posedge scl);
        @(negedge scl); slv_lo = 1'b0;
        wait_irq();
        chk(status_rd == exp, tag, status_rd, exp);
        chk(got == b, {tag, " bus byte"}, got, b);
        chk(start_cnt == s0 && stop_cnt == p0, "R12 no edge in byte", start_cnt + stop_cnt, s0 + p0);
    endtask

    task automatic rx_byte(input logic [7:0] b, input bit aak, input logic [7:0] exp,
                           input string tag);
        logic mack;
        wr(1'b0, aak ? 8'h44 : 8'h40);
        for (int i = 0; i < 8; i++) begin
            slv_lo = ~b[7-i];
            @(posedge scl);
            @(negedge scl);
        end
        slv_lo = 1'b0;
        @(posedge scl); mack = ~sda;
        @(negedge scl);
        wait_irq();
        chk(status_rd == exp, tag, status_rd, exp);
        chk(data_rd == b, {tag, " data"}, data_rd, b);
        chk(mack == aak, {tag, " ack driven"}, mack, aak);
    endtask

    task automatic stop_step();
        int p0;
        p0 = stop_cnt;
        wr(1'b0, 8'h50);
        while (stop_cnt == p0) @(posedge clk);
        repeat (2) @(negedge clk);
        chk(status_rd == 8'hF8, "R8 status after stop", status_rd, 8'hF8);
        chk(!irq && ctl_rd == 8'h40, "R8 flag and stop bit", ctl_rd, 8'h40);
        chk(scl && sda, "R8 lines released", {scl, sda}, 2'b11);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errs, checks);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            checks++; errs++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(status_rd == 8'hF8, "R1 status", status_rd, 8'hF8);
        chk(ctl_rd == 8'h00 && data_rd == 8'h00 && !irq, "R1 regs", ctl_rd, 0);
        chk(scl && sda, "R1 lines", {scl, sda}, 2'b11);

        // R2 flag cannot be set by software; write with flag set is no command
        wr(1'b0, 8'hCF);
        repeat (20) @(negedge clk);
        chk(ctl_rd == 8'hC7, "R2 ctl readback", ctl_rd, 8'hC7);
        chk(start_cnt == 0 && status_rd == 8'hF8, "R2 no command", start_cnt, 0);

        // R10 start without enable does nothing
        wr(1'b0, 8'h20);
        repeat (40) @(negedge clk);
        chk(start_cnt == 0 && scl && sda, "R10 no bus activity", start_cnt, 0);
        chk(status_rd == 8'hF8 && !irq, "R10 status", status_rd, 8'hF8);

        // write transfer
        start_step(8'h08, "R3 start");
        tx_byte(8'hA0, 1'b1, 8'h18, "R4 write addr ack");
        tx_byte(8'h3C, 1'b1, 8'h28, "R5 data ack");
        tx_byte(8'hC5, 1'b0, 8'h30, "R5 data nack");
        stop_step();

        // read transfer with repeated start
        start_step(8'h08, "R3 start 2");
        tx_byte(8'h53, 1'b0, 8'h48, "R4 read addr nack");
        start_step(8'h10, "R7 repeated start");
        tx_byte(8'h34, 1'b0, 8'h20, "R4 write addr nack");
        start_step(8'h10, "R7 repeated start 2");
        tx_byte(8'h53, 1'b1, 8'h40, "R4 read addr ack");
        rx_byte(8'h96, 1'b1, 8'h50, "R6 read ack");
        rx_byte(8'h5A, 1'b0, 8'h58, "R6 read nack");
        stop_step();

        // R9 arbitration loss
        start_step(8'h08, "R3 start 3");
        slv_lo = 1'b1;
        wr(1'b1, 8'hFF);
        wr(1'b0, 8'h40);
        wait_irq();
        chk(status_rd == 8'h38, "R9 status", status_rd, 8'h38);
        chk(!scl_pull && !sda_pull, "R9 released", {scl_pull, sda_pull}, 0);
        slv_lo = 1'b0;
        repeat (10) @(negedge clk);
        chk(status_rd == 8'h38 && irq, "R9 held", status_rd, 8'h38);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule